// File: doc/BRIEF.md
# Double-Buffered DAC Code Register

This block is the digital front end of a 12-bit digital-to-analog converter. Two ranks of storage sit between the data bus and the converter. The first rank is split into an upper 4-bit nibble and a lower 8-bit byte, each with its own load strobe. A host on an 8-bit bus can therefore fill the word in two right-justified writes, and a host on a 16-bit bus can fill it in one write. The second rank holds the code that the converter is driven from. It changes only on a transfer, so the analog output moves in one step from one complete word to the next.

All control inputs are active-low levels sampled on the clock. A master write strobe gates every load. A transfer strobe, qualified by that master strobe, copies the first rank into the second. Any first-rank part that is being written in the same cycle bypasses its latch and goes straight into the second rank, so the final part of a word can be loaded and transferred in one write. An asynchronous active-low reset forces the second rank to mid-scale (0x800, the bipolar-zero code). It does not touch the first rank. Each load of the second rank raises a one-cycle `updated` pulse for downstream logic.

Top module: `dac_input_buffer`

## Requirements
- R1: While `rst_n` is low, `code` is 0x800 (mid-scale, only bit 11 set) and `updated` is 0. This takes effect at once, without a clock, and overrides any transfer request.
- R2: Reset does not affect the first rank. A write made while reset is held is still captured there, and a later transfer presents it.
- R3: While `wr_n` is high, no register changes, whatever the state of the other strobes.
- R4: A write with `ld_lo_n` low and `ld_hi_n` high stores `din[7:0]` as the lower byte and leaves the upper nibble unchanged.
- R5: A write with `ld_hi_n` low and `ld_lo_n` high stores `din[11:8]` as the upper nibble and leaves the lower byte unchanged.
- R6: A write with both first-rank strobes low loads all 12 bits of `din` in one cycle.
- R7: A write with `xfer_n` low and both first-rank strobes high copies the first rank `{nibble, byte}` into `code`. The new value is visible one clock after the sampling edge.
- R8: A write with `xfer_n` low and one or both first-rank strobes low loads `code` from `din` for the parts being written and from the first rank for the other parts. The first rank takes the written parts in the same cycle.
- R9: `updated` is high for exactly the one cycle after each edge that samples `wr_n` and `xfer_n` both low, and low otherwise.
- R10: After reset is released, `code` stays at 0x800 until the first transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for all strobes |
| rst_n | input | 1 | Asynchronous active-low reset of the second rank to mid-scale |
| wr_n | input | 1 | Active-low master write enable |
| ld_hi_n | input | 1 | Active-low load of the upper nibble from din[11:8] |
| ld_lo_n | input | 1 | Active-low load of the lower byte from din[7:0] |
| xfer_n | input | 1 | Active-low transfer into the second rank |
| din | input | 12 | Data bus, bit 0 is the LSB, positive-true |
| code | output | 12 | Registered code presented to the converter |
| updated | output | 1 | One-cycle pulse after each load of the second rank |

## Verification
The bench builds the block with its default split, a 4-bit nibble and an 8-bit byte. This keeps the strobe space small: every one of the 16 combinations of the four strobes is applied repeatedly, each time with varied data, while a reference model of both ranks is kept. That sweep covers every interaction between strobes, including a partial load merged with a transfer and a masked write. Directed sequences add the two-write byte bus, the single 16-bit write, and reset asserted in the middle of a write that is loading and transferring at the same time.

// File: rtl/dacbuf_pkg.sv
package dacbuf_pkg;

  localparam int DACBUF_HI_W = 4;
  localparam int DACBUF_LO_W = 8;

  // Decoded write intent for one sampling cycle.
  typedef struct packed {
    logic hi_we;
    logic lo_we;
    logic xfer;
  } wr_ctl_t;

  // Bipolar-zero code: only the most significant bit set.
  function automatic int unsigned midscale(input int unsigned width);
    return 32'd1 << (width - 1);
  endfunction

  // Value a part of the second rank takes on a transfer: the bus if the part
  // is being written in the same cycle, otherwise the stored first-rank part.
  function automatic logic [15:0] pick_part(input logic we,
                                            input logic [15:0] bus_part,
                                            input logic [15:0] held_part);
    return we ? bus_part : held_part;
  endfunction

endpackage

// File: rtl/dacbuf_strobe_decode.sv
module dacbuf_strobe_decode
  import dacbuf_pkg::*;
(
  input  logic    wr_n,
  input  logic    ld_hi_n,
  input  logic    ld_lo_n,
  input  logic    xfer_n,
  output wr_ctl_t ctl
);

  logic wr_active;

  // Every load is gated by the master write enable.
  assign wr_active = ~wr_n;

  always_comb begin
    ctl.hi_we = wr_active & ~ld_hi_n;
    ctl.lo_we = wr_active & ~ld_lo_n;
    ctl.xfer  = wr_active & ~xfer_n;
  end

endmodule

// File: rtl/dacbuf_rank1.sv
module dacbuf_rank1 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  // First-rank storage has no reset: it keeps its contents through a reset.
  logic [W-1:0] q_r;

  always_ff @(posedge clk) begin
    if (we) q_r <= d;
  end

  assign q = q_r;

endmodule

// File: rtl/dacbuf_rank2.sv
module dacbuf_rank2
  import dacbuf_pkg::*;
#(
  parameter  int HI_W   = DACBUF_HI_W,
  parameter  int LO_W   = DACBUF_LO_W,
  localparam int CODE_W = HI_W + LO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wr_ctl_t           ctl,
  input  logic [CODE_W-1:0] din,
  input  logic [HI_W-1:0]   hi_q,
  input  logic [LO_W-1:0]   lo_q,
  output logic [CODE_W-1:0] code,
  output logic              updated
);

  localparam logic [CODE_W-1:0] MID = CODE_W'(midscale(CODE_W));

  logic [HI_W-1:0]   hi_next;
  logic [LO_W-1:0]   lo_next;
  logic [CODE_W-1:0] code_next;
  logic [CODE_W-1:0] code_r;
  logic              upd_r;

  // Bypass: parts written this cycle come from the bus, not the latch.
  assign hi_next   = HI_W'(pick_part(ctl.hi_we, 16'(din[CODE_W-1:LO_W]), 16'(hi_q)));
  assign lo_next   = LO_W'(pick_part(ctl.lo_we, 16'(din[LO_W-1:0]), 16'(lo_q)));
  assign code_next = {hi_next, lo_next};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_r <= MID;
      upd_r  <= 1'b0;
    end else begin
      upd_r <= ctl.xfer;
      if (ctl.xfer) code_r <= code_next;
    end
  end

  assign code    = code_r;
  assign updated = upd_r;

endmodule

// File: rtl/dac_input_buffer.sv
module dac_input_buffer
  import dacbuf_pkg::*;
#(
  parameter  int HI_W   = DACBUF_HI_W,
  parameter  int LO_W   = DACBUF_LO_W,
  localparam int CODE_W = HI_W + LO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic              ld_hi_n,
  input  logic              ld_lo_n,
  input  logic              xfer_n,
  input  logic [CODE_W-1:0] din,
  output logic [CODE_W-1:0] code,
  output logic              updated
);

  wr_ctl_t         ctl;
  logic [HI_W-1:0] hi_q;
  logic [LO_W-1:0] lo_q;

  dacbuf_strobe_decode u_decode (
    .wr_n    (wr_n),
    .ld_hi_n (ld_hi_n),
    .ld_lo_n (ld_lo_n),
    .xfer_n  (xfer_n),
    .ctl     (ctl)
  );

  dacbuf_rank1 #(.W(HI_W)) u_hi (
    .clk (clk),
    .we  (ctl.hi_we),
    .d   (din[CODE_W-1:LO_W]),
    .q   (hi_q)
  );

  dacbuf_rank1 #(.W(LO_W)) u_lo (
    .clk (clk),
    .we  (ctl.lo_we),
    .d   (din[LO_W-1:0]),
    .q   (lo_q)
  );

  dacbuf_rank2 #(.HI_W(HI_W), .LO_W(LO_W)) u_rank2 (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl     (ctl),
    .din     (din),
    .hi_q    (hi_q),
    .lo_q    (lo_q),
    .code    (code),
    .updated (updated)
  );

endmodule

// File: rtl/dacbuf_checker.sv
module dacbuf_checker
  import dacbuf_pkg::*;
#(
  parameter  int HI_W   = DACBUF_HI_W,
  parameter  int LO_W   = DACBUF_LO_W,
  localparam int CODE_W = HI_W + LO_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_n,
  input logic              ld_hi_n,
  input logic              ld_lo_n,
  input logic              xfer_n,
  input logic [CODE_W-1:0] din,
  input logic [CODE_W-1:0] code,
  input logic              updated,
  input logic [HI_W-1:0]   hi_q,
  input logic [LO_W-1:0]   lo_q
);

  localparam logic [CODE_W-1:0] MID = CODE_W'(midscale(CODE_W));

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_midscale_chk: assert (code == MID && !updated);
    end
  end

  // R3
  idle_code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_n |=> $stable(code));

  // R3
  idle_rank1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_n |=> ($stable(hi_q) && $stable(lo_q)));

  // R4
  lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && !ld_lo_n) |=> lo_q == $past(din[LO_W-1:0]));

  // R5
  hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && !ld_hi_n) |=> hi_q == $past(din[CODE_W-1:LO_W]));

  // R7
  xfer_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && !xfer_n && ld_hi_n && ld_lo_n) |=> code == {$past(hi_q), $past(lo_q)});

  // R8
  xfer_lo_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && !xfer_n && !ld_lo_n) |=> code[LO_W-1:0] == $past(din[LO_W-1:0]));

  // R8
  xfer_hi_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && !xfer_n && !ld_hi_n) |=> code[CODE_W-1:LO_W] == $past(din[CODE_W-1:LO_W]));

  // R9
  updated_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && !xfer_n) |=> updated);

  // R9
  updated_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    updated |-> $past(!wr_n && !xfer_n));

endmodule

bind dac_input_buffer dacbuf_checker #(.HI_W(HI_W), .LO_W(LO_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_n    (wr_n),
  .ld_hi_n (ld_hi_n),
  .ld_lo_n (ld_lo_n),
  .xfer_n  (xfer_n),
  .din     (din),
  .code    (code),
  .updated (updated),
  .hi_q    (hi_q),
  .lo_q    (lo_q)
);

// File: tb/tb_dac_input_buffer.sv
`timescale 1ns/1ps
module tb_dac_input_buffer;

  localparam int HI_W = 4;
  localparam int LO_W = 8;
  localparam int CW   = HI_W + LO_W;
  localparam logic [CW-1:0] MID_EXP = 12'h800;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic          wr_n = 1'b1, ld_hi_n = 1'b1, ld_lo_n = 1'b1, xfer_n = 1'b1;
  logic [CW-1:0] din = '0;
  logic [CW-1:0] code;
  logic          updated;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model of both ranks
  logic [HI_W-1:0] m_hi = '0;
  logic [LO_W-1:0] m_lo = '0;
  logic [CW-1:0]   m_code = 12'h800;
  logic            m_upd = 1'b0;

  always #5 clk = ~clk;

  dac_input_buffer #(.HI_W(HI_W), .LO_W(LO_W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .ld_hi_n(ld_hi_n),
    .ld_lo_n(ld_lo_n), .xfer_n(xfer_n), .din(din),
    .code(code), .updated(updated)
  );

  task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%03h expected=%03h at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at a negedge: drive, update model, wait one cycle, compare.
  task automatic step(input logic wn, input logic hn, input logic ln,
                      input logic xn, input logic [CW-1:0] d, input string tag);
    logic [HI_W-1:0] nh;
    logic [LO_W-1:0] nl;
    wr_n = wn; ld_hi_n = hn; ld_lo_n = ln; xfer_n = xn; din = d;
    m_upd = 1'b0;
    if (!wn) begin
      nh = !hn ? d[CW-1:LO_W] : m_hi;
      nl = !ln ? d[LO_W-1:0] : m_lo;
      if (!xn) begin
        m_code = {nh, nl};
        m_upd  = 1'b1;
      end
      m_hi = nh;
      m_lo = nl;
    end
    @(negedge clk);
    chk(tag, code, m_code);
    chk("R9", {11'd0, updated}, {11'd0, m_upd});
  endtask

  function automatic string tag_of(input logic wn, input logic hn,
                                   input logic ln, input logic xn);
    if (wn) return "R3";
    if (!xn) return (hn && ln) ? "R7" : "R8";
    if (!hn && !ln) return "R6";
    if (!ln) return "R4";
    if (!hn) return "R5";
    return "R3";
  endfunction

  initial begin
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", code, MID_EXP);
    chk("R1", {11'd0, updated}, 12'd0);
    rst_n = 1'b1;
    // R10: no transfer yet, code stays at mid-scale
    step(1'b0, 1'b1, 1'b1, 1'b1, 12'h3C5, "R10");
    step(1'b1, 1'b1, 1'b1, 1'b1, 12'hFFF, "R10");
    // R4/R5 byte-bus sequence: two writes, then transfer
    step(1'b0, 1'b1, 1'b0, 1'b1, 12'h05A, "R4");
    step(1'b0, 1'b0, 1'b1, 1'b1, 12'h700, "R5");
    step(1'b0, 1'b1, 1'b1, 1'b0, 12'h000, "R7");
    // R6 single 16-bit write then transfer
    step(1'b0, 1'b0, 1'b0, 1'b1, 12'hC3E, "R6");
    step(1'b0, 1'b1, 1'b1, 1'b0, 12'h111, "R7");
    // R8 last byte loaded together with transfer
    step(1'b0, 1'b0, 1'b1, 1'b1, 12'h200, "R5");
    step(1'b0, 1'b1, 1'b0, 1'b0, 12'h0F1, "R8");
    // sweep of all strobe combinations with varied data
    for (int k = 0; k < 8; k++) begin
      for (int p = 0; p < 16; p++) begin
        logic [CW-1:0] d;
        d = CW'((p * 32'h9E3 + k * 32'h35B + 32'h5A) & 32'hFFF);
        step(p[3], p[2], p[1], p[0], d, tag_of(p[3], p[2], p[1], p[0]));
      end
    end
    // R1/R2: reset asserted during a load-and-transfer write
    wr_n = 1'b0; ld_hi_n = 1'b0; ld_lo_n = 1'b0; xfer_n = 1'b0; din = 12'hABC;
    #3 rst_n = 1'b0;
    #1 chk("R1", code, MID_EXP);
    @(negedge clk);
    chk("R1", code, MID_EXP);
    chk("R1", {11'd0, updated}, 12'd0);
    m_hi = 4'hA; m_lo = 8'hBC; m_code = MID_EXP;
    wr_n = 1'b1; ld_hi_n = 1'b1; ld_lo_n = 1'b1; xfer_n = 1'b1;
    rst_n = 1'b1;
    step(1'b1, 1'b0, 1'b0, 1'b0, 12'h123, "R10");
    step(1'b0, 1'b1, 1'b1, 1'b0, 12'h456, "R2");
    step(1'b1, 1'b1, 1'b1, 1'b1, 12'h000, "R9");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1..all actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule